// File: doc/BRIEF.md
# Dual-Length Instruction Word Decoder

This block sits between an instruction memory port and an execution stage. It takes 64-bit instruction words over a valid/ready handshake and cuts each word into fields. From the top bit down, a word holds a 32-bit signed constant, a 16-bit signed displacement, a 4-bit source register number, a 4-bit destination register number and an 8-bit opcode. For each complete instruction it hands on one decoded record. The record carries the opcode split into operation, source-select bit and class, the two register numbers, the displacement sign-extended to 64 bits, a 64-bit constant and a flag that marks a double-length instruction.

One opcode, 0x18, marks a two-word instruction that loads a full 64-bit constant. The decoder stores that first word and emits nothing yet. When the next word arrives, it checks that this trailing word is a clean filler and joins the two constants into one 64-bit value. If a register number is out of range, or the filler word is not clean, the decoder raises a one-cycle error pulse with a cause code and emits no record.

The output holds a single record. An instruction word is taken in only when that slot is empty or is being drained in the same cycle. A held record stays unchanged while the consumer stalls.

Top module: `insn_word_decoder`

## Requirements
- R1: A word splits as imm = bits 63:32, offset = bits 31:16, src = bits 15:12, dst = bits 11:8 and opcode = bits 7:0. The record gives class = opcode bits 2:0, source-select = opcode bit 3 (1 picks the src register, 0 picks the constant) and operation = opcode bits 7:4.
- R2: In a single-word record, out_imm is the 32-bit imm sign-extended to 64 bits. In every record, out_offset is the 16-bit offset sign-extended to 64 bits.
- R3: A single-word instruction with dst or src above 10 produces no record and raises err_valid with err_kind bit 0 set.
- R4: A word with opcode 0x18 produces no output until a second word is accepted. The record then has out_wide = 1, the first word's opcode, dst, src and offset, and out_imm = {second word bits 63:32, first word bits 63:32}.
- R5: On the two-word form the src field is not range-checked, so any src value 0 to 15 passes through unchanged.
- R6: If the second word has any nonzero bit in 31:0, the pair gives no record and err_kind bit 1 is set. If the first word's dst is above 10, err_kind bit 0 is set when the second word arrives. Both bits may be set together.
- R7: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, every record output holds its value.
- R8: A synchronous reset empties the output slot and drops a stored first half, so the next word is decoded as the start of a new instruction.
- R9: err_valid is high for exactly the one cycle after the clock edge that accepts the word completing a rejected instruction. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_class | output | 3 | Instruction class |
| out_src_sel | output | 1 | Source select: 1 register, 0 constant |
| out_op | output | 4 | Operation code |
| out_opcode | output | 8 | Whole opcode byte |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source register number or source field |
| out_offset | output | 64 | Sign-extended displacement |
| out_imm | output | 64 | 64-bit constant |
| out_wide | output | 1 | Record came from a two-word instruction |
| err_valid | output | 1 | One-cycle pulse for a rejected instruction |
| err_kind | output | 2 | Cause: bit 0 register range, bit 1 unclean second word |

## Verification
Some properties hold on every cycle, and the assertions watch those. They cover the stability of a stalled record, no load into a full slot, register numbers in range on every single-word record, sign extension of the displacement and the single-word constant, the 0x18 opcode on every two-word record, and a stored first half that waits for its partner. Only the bench scenarios can show that the right values come out and in the right order. That covers the joining of the two constants (including a low half with its top bit set), the error cause codes, the lack of a src check on the two-word form, and a reset that drops a stored first half. The bench compares each record and error pulse against a model queue, under random back-pressure and random gaps at the input.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned IMM_W  = 32;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned REG_W  = 4;
    localparam int unsigned OPC_W  = 8;
    localparam int unsigned CLS_W  = 3;
    localparam int unsigned OP_W   = OPC_W - CLS_W - 1;
    localparam int unsigned ERR_W  = 2;
    localparam int unsigned ERR_REG_BIT    = 0;
    localparam int unsigned ERR_PSEUDO_BIT = 1;

    typedef struct packed {
        logic [IMM_W-1:0] imm;
        logic [OFF_W-1:0] off;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [OPC_W-1:0] opc;
    } raw_word_t;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic              src_sel;
        logic [OP_W-1:0]   op;
        logic [OPC_W-1:0]  opc;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] imm;
        logic              wide;
    } dec_rec_t;

    typedef enum logic {
        PAIR_IDLE = 1'b0,
        PAIR_HALF = 1'b1
    } pair_state_e;

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] sext_off(input logic [OFF_W-1:0] v);
        return {{(WORD_W-OFF_W){v[OFF_W-1]}}, v};
    endfunction

    function automatic logic reg_over(input logic [REG_W-1:0] r, input int unsigned lim);
        return 32'(r) > lim;
    endfunction

    function automatic logic filler_dirty(input raw_word_t w);
        return (w.opc != '0) || (w.dst != '0) || (w.src != '0) || (w.off != '0);
    endfunction

endpackage

// File: rtl/iwd_field_split.sv
module iwd_field_split
    import iwd_pkg::*;
#(
    parameter int unsigned     REG_LIMIT   = 10,
    parameter logic [OPC_W-1:0] WIDE_OPCODE = 8'h18
) (
    input  raw_word_t word,
    output dec_rec_t  rec,
    output logic      wide_head,
    output logic      dst_bad,
    output logic      src_bad,
    output logic      pseudo_bad
);

    always_comb begin
        wide_head   = (word.opc == WIDE_OPCODE);
        dst_bad     = reg_over(word.dst, REG_LIMIT);
        src_bad     = reg_over(word.src, REG_LIMIT);
        pseudo_bad  = filler_dirty(word);

        rec.cls     = word.opc[CLS_W-1:0];
        rec.src_sel = word.opc[CLS_W];
        rec.op      = word.opc[OPC_W-1:CLS_W+1];
        rec.opc     = word.opc;
        rec.dst     = word.dst;
        rec.src     = word.src;
        rec.off     = sext_off(word.off);
        rec.imm     = sext_imm(word.imm);
        rec.wide    = wide_head;
    end

endmodule

// File: rtl/iwd_pair_ctrl.sv
module iwd_pair_ctrl
    import iwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  dec_rec_t         split_rec,
    input  logic [IMM_W-1:0] hi_imm,
    input  logic             wide_head,
    input  logic             dst_bad,
    input  logic             src_bad,
    input  logic             pseudo_bad,
    output logic             emit,
    output dec_rec_t         emit_rec,
    output logic             err_fire,
    output logic [ERR_W-1:0] err_code,
    output logic             pending
);

    pair_state_e state_q, state_d;
    dec_rec_t    held_q;
    logic        held_bad_q;

    assign pending = (state_q == PAIR_HALF);

    always_comb begin
        state_d  = state_q;
        emit     = 1'b0;
        err_fire = 1'b0;
        err_code = '0;
        emit_rec = split_rec;
        if (accept) begin
            if (state_q == PAIR_IDLE) begin
                if (wide_head) begin
                    state_d = PAIR_HALF;
                end else if (dst_bad || src_bad) begin
                    err_fire              = 1'b1;
                    err_code[ERR_REG_BIT] = 1'b1;
                end else begin
                    emit = 1'b1;
                end
            end else begin
                state_d                  = PAIR_IDLE;
                err_code[ERR_REG_BIT]    = held_bad_q;
                err_code[ERR_PSEUDO_BIT] = pseudo_bad;
                err_fire                 = held_bad_q || pseudo_bad;
                emit                     = !(held_bad_q || pseudo_bad);
                emit_rec                 = held_q;
                emit_rec.imm             = {hi_imm, held_q.imm[IMM_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PAIR_IDLE;
            held_q     <= '0;
            held_bad_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && state_q == PAIR_IDLE && wide_head) begin
                held_q     <= split_rec;
                held_bad_q <= dst_bad;
            end
        end
    end

    // R4
    half_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !accept) |=> pending);

    // R6
    pair_close_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && accept) |=> !pending);

endmodule

// File: rtl/iwd_out_stage.sv
module iwd_out_stage
    import iwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  dec_rec_t         load_rec,
    input  logic             err_fire,
    input  logic [ERR_W-1:0] err_code,
    input  logic             out_ready,
    output logic             out_valid,
    output dec_rec_t         out_rec,
    output logic             err_valid,
    output logic [ERR_W-1:0] err_kind,
    output logic             in_ready
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rec   <= '0;
            err_valid <= 1'b0;
            err_kind  <= '0;
        end else begin
            if (load) begin
                out_valid <= 1'b1;
                out_rec   <= load_rec;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            err_valid <= err_fire;
            err_kind  <= err_fire ? err_code : '0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

    // R7
    load_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (!out_valid || out_ready));

    // R9
    err_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        err_fire |-> !load);

endmodule

// File: rtl/insn_word_decoder.sv
module insn_word_decoder
    import iwd_pkg::*;
#(
    parameter int unsigned      REG_LIMIT   = 10,
    parameter logic [OPC_W-1:0] WIDE_OPCODE = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CLS_W-1:0]  out_class,
    output logic              out_src_sel,
    output logic [OP_W-1:0]   out_op,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [REG_W-1:0]  out_dst,
    output logic [REG_W-1:0]  out_src,
    output logic [WORD_W-1:0] out_offset,
    output logic [WORD_W-1:0] out_imm,
    output logic              out_wide,
    output logic              err_valid,
    output logic [ERR_W-1:0]  err_kind
);

    raw_word_t        raw;
    dec_rec_t         split_rec, emit_rec, out_rec;
    logic             wide_head, dst_bad, src_bad, pseudo_bad;
    logic             accept, emit, err_fire, pending;
    logic [ERR_W-1:0] err_code;

    assign raw    = raw_word_t'(in_word);
    assign accept = in_valid && in_ready;

    iwd_field_split #(
        .REG_LIMIT   (REG_LIMIT),
        .WIDE_OPCODE (WIDE_OPCODE)
    ) u_split (
        .word       (raw),
        .rec        (split_rec),
        .wide_head  (wide_head),
        .dst_bad    (dst_bad),
        .src_bad    (src_bad),
        .pseudo_bad (pseudo_bad)
    );

    iwd_pair_ctrl u_pair (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .split_rec  (split_rec),
        .hi_imm     (raw.imm),
        .wide_head  (wide_head),
        .dst_bad    (dst_bad),
        .src_bad    (src_bad),
        .pseudo_bad (pseudo_bad),
        .emit       (emit),
        .emit_rec   (emit_rec),
        .err_fire   (err_fire),
        .err_code   (err_code),
        .pending    (pending)
    );

    iwd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .load_rec  (emit_rec),
        .err_fire  (err_fire),
        .err_code  (err_code),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_rec   (out_rec),
        .err_valid (err_valid),
        .err_kind  (err_kind),
        .in_ready  (in_ready)
    );

    assign out_class   = out_rec.cls;
    assign out_src_sel = out_rec.src_sel;
    assign out_op      = out_rec.op;
    assign out_opcode  = out_rec.opc;
    assign out_dst     = out_rec.dst;
    assign out_src     = out_rec.src;
    assign out_offset  = out_rec.off;
    assign out_imm     = out_rec.imm;
    assign out_wide    = out_rec.wide;

    // R3
    out_dst_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(out_dst) <= REG_LIMIT));

    // R3
    out_src_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wide) |-> (32'(out_src) <= REG_LIMIT));

    // R2
    imm_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wide) |-> (out_imm[WORD_W-1:IMM_W] == {(WORD_W-IMM_W){out_imm[IMM_W-1]}}));

    // R2
    off_sext_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_offset[WORD_W-1:OFF_W] == {(WORD_W-OFF_W){out_offset[OFF_W-1]}}));

    // R4
    wide_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wide) |-> (out_opcode == WIDE_OPCODE));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_kind != '0));

endmodule

// File: tb/insn_word_decoder_test.sv
module insn_word_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_class;
    logic        out_src_sel;
    logic [3:0]  out_op;
    logic [7:0]  out_opcode;
    logic [3:0]  out_dst;
    logic [3:0]  out_src;
    logic [63:0] out_offset;
    logic [63:0] out_imm;
    logic        out_wide;
    logic        err_valid;
    logic [1:0]  err_kind;

    always #5 clk = ~clk;

    insn_word_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_class(out_class), .out_src_sel(out_src_sel), .out_op(out_op),
        .out_opcode(out_opcode), .out_dst(out_dst), .out_src(out_src),
        .out_offset(out_offset), .out_imm(out_imm), .out_wide(out_wide),
        .err_valid(err_valid), .err_kind(err_kind)
    );

    typedef struct {
        bit        is_err;
        bit [1:0]  kind;
        bit [7:0]  opc;
        bit [3:0]  dst;
        bit [3:0]  src;
        bit [63:0] off;
        bit [63:0] imm;
        bit        wide;
    } expect_t;

    expect_t     eq[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [63:0] words[0:1023];
    int          n_words  = 0;

    bit          m_pend = 1'b0;
    bit          m_bad  = 1'b0;
    bit [63:0]   m_first = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [63:0] sx32(input bit [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic bit [63:0] sx16(input bit [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    function automatic bit [63:0] mk(input bit [31:0] imm, input bit [15:0] off,
                                     input bit [3:0] src, input bit [3:0] dst, input bit [7:0] opc);
        return {imm, off, src, dst, opc};
    endfunction

    task automatic model_accept(input bit [63:0] w);
        expect_t e;
        e.is_err = 0; e.kind = 0; e.wide = 0;
        if (!m_pend) begin
            if (w[7:0] == 8'h18) begin
                m_pend  = 1;
                m_first = w;
                m_bad   = (w[11:8] > 4'd10);
                return;
            end
            if (w[11:8] > 4'd10 || w[15:12] > 4'd10) begin
                e.is_err = 1; e.kind = 2'b01;
            end else begin
                e.opc = w[7:0]; e.dst = w[11:8]; e.src = w[15:12];
                e.off = sx16(w[31:16]); e.imm = sx32(w[63:32]);
            end
        end else begin
            m_pend = 0;
            e.kind = {w[31:0] != 0, m_bad};
            if (e.kind != 0) begin
                e.is_err = 1;
            end else begin
                e.opc = m_first[7:0]; e.dst = m_first[11:8]; e.src = m_first[15:12];
                e.off = sx16(m_first[31:16]); e.imm = {w[63:32], m_first[63:32]};
                e.wide = 1;
            end
        end
        eq.push_back(e);
    endtask

    task automatic observe();
        expect_t e;
        if (err_valid) begin
            if (eq.size() == 0) begin
                chk(0, "R9 unexpected error pulse", {62'd0, err_kind}, 64'd0);
            end else begin
                e = eq.pop_front();
                chk(e.is_err, "R9 error pulse where a record was due", 64'd1, 64'd0);
                // R3 R6 cause code
                chk(err_kind == e.kind, "R6 error cause", {62'd0, err_kind}, {62'd0, e.kind});
            end
        end
        if (out_valid && out_ready) begin
            if (eq.size() == 0) begin
                chk(0, "R3 unexpected record", out_imm, 64'd0);
            end else begin
                e = eq.pop_front();
                chk(!e.is_err, "R3 record where an error was due", 64'd1, 64'd0);
                // R1 field split
                chk(out_opcode == e.opc && out_class == e.opc[2:0] && out_src_sel == e.opc[3]
                    && out_op == e.opc[7:4], "R1 opcode split", {56'd0, out_opcode}, {56'd0, e.opc});
                chk(out_dst == e.dst && out_src == e.src, "R5 register fields",
                    {56'd0, out_src, out_dst}, {56'd0, e.src, e.dst});
                chk(out_offset == e.off, "R2 offset", out_offset, e.off);
                chk(out_imm == e.imm, e.wide ? "R4 joined constant" : "R2 constant", out_imm, e.imm);
                chk(out_wide == e.wide, "R4 wide flag", {63'd0, out_wide}, {63'd0, e.wide});
            end
        end
    endtask

    task automatic run_words(input int lo, input int hi);
        int  idx  = lo;
        bit  took = 0;
        int  guard = 0;
        while ((idx <= hi || eq.size() > 0 || in_valid) && guard < 20000) begin
            guard++;
            @(negedge clk);
            if (took) begin
                in_valid = 0;
                took = 0;
            end
            out_ready = (idx > hi) ? 1'b1 : (($urandom % 10) < 7);
            observe();
            if (!in_valid && idx <= hi && ($urandom % 4) != 0) begin
                in_word  = words[idx];
                in_valid = 1;
            end
            #1;
            // R7 ready rule
            chk(in_ready == (!out_valid || out_ready), "R7 in_ready", {63'd0, in_ready},
                {63'd0, (!out_valid || out_ready)});
            if (in_valid && in_ready) begin
                model_accept(in_word);
                idx++;
                took = 1;
            end
        end
        chk(eq.size() == 0, "R3 expectations left over", 64'(eq.size()), 64'd0);
    endtask

    task automatic add(input bit [63:0] w);
        words[n_words] = w;
        n_words++;
    endtask

    initial begin
        int unused_seed;
        int d_end;
        unused_seed = $urandom(32'd4242);

        // directed words
        add(mk(32'hFFFF_FF85, 16'h8001, 4'd3, 4'd2, 8'hCF));   // R2 negative fields, reg source
        add(mk(32'h0000_1234, 16'h7FFF, 4'd10, 4'd10, 8'h04)); // R3 limit 10 legal
        add(mk(32'h0, 16'h0, 4'd0, 4'd11, 8'h07));             // R3 dst 11
        add(mk(32'h0, 16'h0, 4'd11, 4'd0, 8'h0F));             // R3 src 11
        add(mk(32'h8000_0000, 16'hFFFE, 4'd15, 4'd5, 8'h18));  // R5 src 15, R4 low half top bit
        add(mk(32'h1357_9BDF, 16'h0, 4'd0, 4'd0, 8'h00));
        add(mk(32'h0000_0001, 16'h0, 4'd1, 4'd1, 8'h18));      // R6 dirty filler
        add(mk(32'h0000_0002, 16'h0004, 4'd0, 4'd0, 8'h00));
        add(mk(32'h0000_0003, 16'h0, 4'd0, 4'd12, 8'h18));     // R6 first half dst 12
        add(mk(32'h0000_0004, 16'h0, 4'd0, 4'd0, 8'h00));
        add(mk(32'h0000_0005, 16'h0, 4'd0, 4'd13, 8'h18));     // R6 both causes
        add(mk(32'h0000_0006, 16'h0, 4'd0, 4'd0, 8'h05));
        d_end = n_words - 1;

        // random words
        for (int i = 0; i < 400; i++) begin
            bit [7:0] opc = 8'($urandom);
            if (($urandom % 10) < 3) begin
                add(mk($urandom, 16'($urandom), 4'($urandom), 4'($urandom % 12), 8'h18));
                if (($urandom % 5) == 0)
                    add({32'($urandom), 32'($urandom | 1)});
                else
                    add({32'($urandom), 32'd0});
            end else begin
                if (opc == 8'h18) opc = 8'h07;
                add(mk($urandom, 16'($urandom), 4'($urandom % 12), 4'($urandom % 12), opc));
            end
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R8 reset state
        chk(!out_valid, "R8 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk(!err_valid, "R9 err_valid after reset", {63'd0, err_valid}, 64'd0);
        chk(in_ready, "R7 in_ready after reset", {63'd0, in_ready}, 64'd1);

        run_words(0, d_end);

        // R8: reset drops a stored first half
        @(negedge clk);
        out_ready = 1;
        in_word   = mk(32'hAAAA_0000, 16'h0, 4'd0, 4'd1, 8'h18);
        in_valid  = 1;
        @(negedge clk);
        in_valid = 0;
        chk(!out_valid, "R4 first half withheld", {63'd0, out_valid}, 64'd0);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_pend = 0;
        words[0] = mk(32'h0000_0077, 16'h0010, 4'd2, 4'd3, 8'h0C);
        run_words(0, 0);

        run_words(d_end + 1, n_words - 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule